// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It holds four 16-bit segment base registers: code, data, extra and stack. Software-visible logic elsewhere in the processor loads them through a single write port. On every request the block receives an offset together with a code that says which pointer the offset came from, plus a flag marking string-destination accesses. From these it picks the segment register that addressing convention pairs with that pointer. It appends four zero bits below the segment value and adds the offset.

The address and the identity of the chosen segment come out combinationally in the same cycle as the request. A segment write is registered and is first seen by requests in the following cycle. Because any segment may start at any multiple of 16 bytes, segments may overlap freely. The sum wraps inside the 1 MB space.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment value × 16 + `req_off`) in the same cycle as the request, using the segment reported on `seg_used`.
- R2: `req_src` = 0 (instruction pointer) always selects the code segment, reported as `seg_used` = 1.
- R3: `req_src` = 1 (stack pointer) and `req_src` = 2 (base pointer) select the stack segment, reported as `seg_used` = 2.
- R4: `req_src` = 3 (BX), 4 (SI), the unused codes 6 and 7, and 5 (DI) with `req_str_dst` = 0 all select the data segment, reported as `seg_used` = 3.
- R5: `req_src` = 5 (DI) with `req_str_dst` = 1 selects the extra segment, reported as `seg_used` = 0. For every other `req_src` the flag has no effect on the address or on `seg_used`.
- R6: With `seg_wr_en` high at a rising edge, the register named by `seg_wr_sel` (0 extra, 1 code, 2 stack, 3 data) takes `seg_wr_data`. The other three registers keep their values.
- R7: A request in the same cycle as a write sees the old segment value. The new value is used from the next cycle on.
- R8: After reset the code segment holds FFFF hex and the other three hold zero, so an instruction fetch at offset 0 gives FFFF0 hex.
- R9: A carry out of bit 19 is dropped: stack segment FFFF with offset FFFF gives 0FFEF hex.
- R10: Segment A4FB with offset 4872 gives A9822 hex. Segment 34BA with offset 8AB4 gives 3D654 hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Load the selected segment register |
| seg_wr_sel | input | 2 | Register to load: 0 extra, 1 code, 2 stack, 3 data |
| seg_wr_data | input | 16 | New segment value |
| req_src | input | 3 | Offset source: 0 IP, 1 SP, 2 BP, 3 BX, 4 SI, 5 DI |
| req_str_dst | input | 1 | Request is a string-operation destination |
| req_off | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Resulting physical address |
| seg_used | output | 2 | Segment that formed the address, same code as seg_wr_sel |

## Verification
The bench builds the block with its default widths: 16-bit segments, 16-bit offsets and a 4-bit shift. With these widths the whole 1 MB space and its wrap-around can be reached with ordinary register values. It drives the reset-state fetch, the two worked address examples, a write that collides with a request to the same segment, the top-of-memory wrap, and the string flag on every source code. A long run then draws writes and requests at random and compares the address and segment code on every cycle.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic [2:0]       req_src,
  input  logic             req_str_dst,
  input  logic [OFF_W-1:0] req_off,
  output logic [PA_W-1:0]  phys_addr,
  output logic [1:0]       seg_used
);

  localparam logic [1:0] SEG_EXTRA = 2'd0;
  localparam logic [1:0] SEG_CODE  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_DATA  = 2'd3;

  localparam logic [2:0] SRC_IP = 3'd0;
  localparam logic [2:0] SRC_SP = 3'd1;
  localparam logic [2:0] SRC_BP = 3'd2;
  localparam logic [2:0] SRC_DI = 3'd5;

  logic [SEG_W-1:0] seg_q [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++)
        seg_q[i] <= (i == int'(SEG_CODE)) ? CODE_RST : '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  always_comb begin
    case (req_src)
      SRC_IP:         seg_used = SEG_CODE;
      SRC_SP, SRC_BP: seg_used = SEG_STACK;
      SRC_DI:         seg_used = req_str_dst ? SEG_EXTRA : SEG_DATA;
      default:        seg_used = SEG_DATA;
    endcase
  end

  assign phys_addr = {seg_q[seg_used], {SHIFT{1'b0}}} + PA_W'(req_off);

endmodule

module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_wr_en,
  input logic [1:0]       seg_wr_sel,
  input logic [SEG_W-1:0] seg_wr_data,
  input logic [2:0]       req_src,
  input logic             req_str_dst,
  input logic [OFF_W-1:0] req_off,
  input logic [PA_W-1:0]  phys_addr,
  input logic [1:0]       seg_used
);

  logic [PA_W-1:0] base_back;
  assign base_back = phys_addr - PA_W'(req_off);

  a_r2_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src == 3'd0) |-> (seg_used == 2'd1));

  a_r3_stack_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src == 3'd1 || req_src == 3'd2) |-> (seg_used == 2'd2));

  a_r4_data_default: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src == 3'd3 || req_src == 3'd4 || req_src == 3'd6 || req_src == 3'd7 ||
     (req_src == 3'd5 && !req_str_dst)) |-> (seg_used == 2'd3));

  a_r5_string_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src == 3'd5 && req_str_dst) |-> (seg_used == 2'd0));

  a_r1_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[SHIFT-1:0] == req_off[SHIFT-1:0]);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> (seg_used != $past(seg_wr_sel)) ||
                  (base_back == {$past(seg_wr_data), {SHIFT{1'b0}}}));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
  .seg_wr_data(seg_wr_data), .req_src(req_src), .req_str_dst(req_str_dst),
  .req_off(req_off), .phys_addr(phys_addr), .seg_used(seg_used)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [2:0]  req_src = '0;
  logic        req_str_dst = 1'b0;
  logic [15:0] req_off = '0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int model_seg [4];

  always #2 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .req_src(req_src), .req_str_dst(req_str_dst),
    .req_off(req_off), .phys_addr(phys_addr), .seg_used(seg_used)
  );

  function automatic int pick_seg(int src, bit sd);
    if (src == 0) return 1;
    if (src == 1 || src == 2) return 2;
    if (src == 5 && sd) return 0;
    return 3;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic step(bit we, int ws, int wd, int src, bit sd, int off, string tag);
    int es, ea;
    @(negedge clk);
    seg_wr_en = we; seg_wr_sel = 2'(ws); seg_wr_data = 16'(wd);
    req_src = 3'(src); req_str_dst = sd; req_off = 16'(off);
    #1;
    es = pick_seg(src, sd);
    ea = ((model_seg[es] << 4) + off) & 32'hFFFFF;
    check(int'(seg_used) == es, {tag, " segment"}, int'(seg_used), es);
    check(int'(phys_addr) == ea, {tag, " address"}, int'(phys_addr), ea);
    @(posedge clk);
    if (we) model_seg[ws] = wd;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_seg[0] = 0; model_seg[1] = 'hFFFF; model_seg[2] = 0; model_seg[3] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8: reset values
    step(0, 0, 0, 0, 0, 'h0000, "R8 fetch after reset");
    step(0, 0, 0, 1, 0, 'h0123, "R8 stack after reset");
    step(0, 0, 0, 5, 1, 'h0040, "R8 extra after reset");
    // R10: worked examples
    step(1, 3, 'hA4FB, 2, 0, 0, "R6 write data");
    step(0, 0, 0, 3, 0, 'h4872, "R10 A4FB:4872");
    step(1, 1, 'h34BA, 0, 0, 'h8AB4, "R7 old code before write");
    step(0, 0, 0, 0, 0, 'h8AB4, "R10 34BA:8AB4");
    // R7: collision then new value
    step(1, 0, 'h1234, 5, 1, 'h0010, "R7 same-cycle extra");
    step(0, 0, 0, 5, 1, 'h0010, "R7 next-cycle extra");
    step(0, 0, 0, 5, 0, 'h0010, "R4 DI without flag");
    // R9: wrap
    step(1, 2, 'hFFFF, 1, 0, 'hFFFF, "R7 stack old");
    step(0, 0, 0, 1, 0, 'hFFFF, "R9 wrap stack");
    step(0, 0, 0, 2, 1, 'hFFFF, "R5 flag ignored on BP");
    // R4 and R5 across all sources with the flag
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 0, s, 1, 'h0ABC, "R5 flag sweep");
      step(0, 0, 0, s, 0, 'h0ABC, "R4 source sweep");
    end
    // R1 R2 R3 R6 random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, $urandom % 4, $urandom % 65536,
           $urandom % 8, $urandom % 2, $urandom % 65536, "R1 random");
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule